// File: doc/BRIEF.md
# BCD Seven-Segment Decoder with Enable

This block turns one binary-coded decimal digit into the seven lamp drives of a single display position. The four-bit input is read as an unsigned number, with bit 3 as the most significant bit. Values 0 to 9 light a fixed set of segments. Values 10 to 15 blank the position. An active-high enable turns the whole display off without any change to the digit input.

The glyphs come from one sixteen-bit minterm mask per segment. Each segment line is the mask bit picked out by the input code. The segment numbering is the block's own, and the digit 6 glyph has no top bar.

A parameter chooses how the result leaves the block. By default it passes through one output register with a synchronous active-low reset, so the block can run against a clock. With the parameter cleared, the output is pure gating logic and the clock and reset are unused.

Top module: `seg7_bcd_decoder`

## Requirements
- R1: Output bit i drives segment i, and a 1 lights the lamp. The bits map to positions as follows: 0 top bar, 1 upper-left, 2 upper-right, 3 middle bar, 4 lower-left, 5 lower-right, 6 bottom bar.
- R2: While `en` is 0, all seven segment bits are 0 for every value of `digit`.
- R3: While `en` is 1, a `digit` value from 10 to 15 gives all seven segment bits 0.
- R4: When enabled, the top bar (bit 0) is lit for 0, 2, 3, 5, 7, 8, 9. The upper-left (bit 1) is lit for 0, 4, 5, 6, 8, 9.
- R5: When enabled, the upper-right (bit 2) is lit for 0, 1, 2, 3, 4, 7, 8, 9. The middle bar (bit 3) is lit for 2, 3, 4, 5, 6, 8, 9.
- R6: When enabled, the lower-left (bit 4) is lit for 0, 2, 6, 8. The lower-right (bit 5) is lit for every digit except 2. The bottom bar (bit 6) is lit for 0, 2, 3, 5, 6, 8.
- R7: Digit 6 shows 7'h7A, with no top bar. Digit 7 shows 7'h25 (top bar and both right verticals). Every digit from 0 to 9, when enabled, lights at least one segment.
- R8: With `REG_OUT`=1, `seg` shows the result for the inputs sampled at the previous rising clock edge. A low `rst_n` at a rising edge clears `seg` to 0 at that edge.
- R9: With `REG_OUT`=0, `seg` follows `en` and `digit` in the same cycle, with no storage.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Synchronous active-low reset of the output register |
| en | input | 1 | Display enable, active high |
| digit | input | 4 | BCD digit, unsigned, bit 3 most significant |
| seg | output | 7 | Segment drives, active high, bit i = segment i |

## Verification
The bench targets several corner cases:
- Codes 10 to 15 with the enable high. A decoder that indexed its masks without a range rule, or that had a mask bit set above 9, would show a stray glyph here.
- Codes 10 to 15 with the enable low.
- Digits 6 and 7, where the non-standard glyphs differ from the usual shapes. A design using the common seven-segment order would light the top bar on 6.
- A reset asserted while a full 8 is shown, which must blank the next cycle.

It also sweeps every enable and code pair through both output variants. A swapped segment index or an off-by-one latency shows up as a mismatch on many of these vectors.

// File: rtl/seg7_pkg.sv
// Shared constants and types for the BCD seven-segment decoder.
// Assumes a four-bit code and seven segments. The per-segment minterm
// masks are indexed by the input code, bit k = lit for code k.
package seg7_pkg;

    localparam int CODE_W    = 4;
    localparam int NUM_SEG   = 7;
    localparam int NUM_CODES = 1 << CODE_W;
    localparam int MAX_DIGIT = 9;

    typedef logic [CODE_W-1:0]    code_t;
    typedef logic [NUM_SEG-1:0]   seg_t;
    typedef logic [NUM_CODES-1:0] minterm_mask_t;

    // Segment order: top, upper-left, upper-right, middle, lower-left,
    // lower-right, bottom. Bits 10..15 of every mask stay zero.
    localparam minterm_mask_t SEG_MINTERMS [NUM_SEG] = '{
        16'h03AD,   // top bar:     0 2 3 5 7 8 9
        16'h0371,   // upper-left:  0 4 5 6 8 9
        16'h039F,   // upper-right: 0 1 2 3 4 7 8 9
        16'h037C,   // middle bar:  2 3 4 5 6 8 9
        16'h0145,   // lower-left:  0 2 6 8
        16'h03FB,   // lower-right: all but 2
        16'h016D    // bottom bar:  0 2 3 5 6 8
    };

endpackage

// File: rtl/seg7_code_check.sv
// Flags whether a code is a legal decimal digit (0..MAX_DIGIT).
// Assumes unsigned input. Purely combinational.
module seg7_code_check
    import seg7_pkg::*;
(
    input  code_t code_i,
    output logic  valid_o
);

    // Range compare against the largest decimal digit.
    always_comb begin
        valid_o = (code_i <= CODE_W'(MAX_DIGIT));
    end

endmodule

// File: rtl/seg7_minterm_rom.sv
// Builds each segment line as one bit of its minterm mask, picked by the code.
// Assumes the masks in seg7_pkg. Codes above 9 are not filtered here.
module seg7_minterm_rom
    import seg7_pkg::*;
(
    input  code_t code_i,
    output seg_t  glyph_o
);

    // One lookup per segment, repeated across the segment count.
    for (genvar g = 0; g < NUM_SEG; g++) begin : g_seg
        assign glyph_o[g] = SEG_MINTERMS[g][code_i];
    end

endmodule

// File: rtl/seg7_out_stage.sv
// Gates the glyph with the show condition and optionally registers it.
// Assumes a synchronous active-low reset. Clock and reset are unused
// when REG_OUT is 0.
module seg7_out_stage
    import seg7_pkg::*;
#(
    parameter bit REG_OUT = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic show_i,
    input  seg_t glyph_i,
    output seg_t seg_o
);

    seg_t gated;

    // Force every segment dark unless the display is allowed to show.
    always_comb begin
        gated = show_i ? glyph_i : '0;
    end

    if (REG_OUT) begin : g_reg
        seg_t seg_q;

        // Output register with synchronous clear.
        always_ff @(posedge clk) begin
            if (!rst_n) seg_q <= '0;
            else        seg_q <= gated;
        end

        assign seg_o = seg_q;
    end else begin : g_comb
        logic unused_clk_rst;
        assign unused_clk_rst = &{1'b0, clk, rst_n};
        assign seg_o          = gated;
    end

endmodule

// File: rtl/seg7_bcd_decoder.sv
// BCD to seven-segment decoder with enable and blanking of codes 10..15.
// Assumes active-high segments and the block's own segment order.
// REG_OUT selects a registered (1) or combinational (0) output.
module seg7_bcd_decoder
    import seg7_pkg::*;
#(
    parameter bit REG_OUT = 1'b1
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       en,
    input  logic [3:0] digit,
    output logic [6:0] seg
);

    logic code_ok;
    logic show;
    seg_t glyph;

    seg7_code_check u_check (
        .code_i  (digit),
        .valid_o (code_ok)
    );

    seg7_minterm_rom u_rom (
        .code_i  (digit),
        .glyph_o (glyph)
    );

    // The display shows only a legal digit while enabled.
    always_comb begin
        show = en & code_ok;
    end

    seg7_out_stage #(.REG_OUT(REG_OUT)) u_out (
        .clk     (clk),
        .rst_n   (rst_n),
        .show_i  (show),
        .glyph_i (glyph),
        .seg_o   (seg)
    );

    if (REG_OUT) begin : g_chk_reg
        AST_DARK_WHEN_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
            !en |=> (seg == 7'd0));                                           // R2
        AST_BLANK_ILLEGAL_CODE: assert property (@(posedge clk) disable iff (!rst_n)
            (en && digit > 4'd9) |=> (seg == 7'd0));                          // R3
        AST_LEGAL_DIGIT_LIT: assert property (@(posedge clk) disable iff (!rst_n)
            (en && digit <= 4'd9) |=> (seg != 7'd0));                         // R7
        AST_RESET_CLEARS: assert property (@(posedge clk)
            !rst_n |=> (seg == 7'd0));                                        // R8
    end else begin : g_chk_comb
        AST_DARK_WHEN_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
            !en |-> (seg == 7'd0));                                           // R2
        AST_BLANK_ILLEGAL_CODE: assert property (@(posedge clk) disable iff (!rst_n)
            (en && digit > 4'd9) |-> (seg == 7'd0));                          // R3
        AST_LEGAL_DIGIT_LIT: assert property (@(posedge clk) disable iff (!rst_n)
            (en && digit <= 4'd9) |-> (seg != 7'd0));                         // R7
        AST_NO_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
            (en && digit == 4'd8) |-> (seg == 7'h7F));                        // R9
    end

endmodule

// File: tb/test_seg7_bcd_decoder.sv
// Bench: full sweep, seeded random vectors and directed corners.
// Checks a registered and a combinational instance.
module test_seg7_bcd_decoder;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       en = 1'b0;
    logic [3:0] digit = 4'd0;
    logic [6:0] seg_r;
    logic [6:0] seg_c;
    int         n_checks = 0;
    int         n_fail = 0;

    always #4 clk = ~clk;   // 125 MHz

    seg7_bcd_decoder #(.REG_OUT(1'b1)) i_seg7_bcd_decoder (
        .clk (clk), .rst_n (rst_n), .en (en), .digit (digit), .seg (seg_r)
    );

    seg7_bcd_decoder #(.REG_OUT(1'b0)) i_seg7_bcd_decoder_comb (
        .clk (clk), .rst_n (rst_n), .en (en), .digit (digit), .seg (seg_c)
    );

    // Expected glyphs, written per digit with bit i = segment i.
    function automatic logic [6:0] ref_seg(input logic e, input logic [3:0] d);
        if (!e) return 7'h00;
        case (d)
            4'd0: return 7'h77;
            4'd1: return 7'h24;
            4'd2: return 7'h5D;
            4'd3: return 7'h6D;
            4'd4: return 7'h2E;
            4'd5: return 7'h6B;
            4'd6: return 7'h7A;
            4'd7: return 7'h25;
            4'd8: return 7'h7F;
            4'd9: return 7'h2F;
            default: return 7'h00;
        endcase
    endfunction

    function automatic string tag_of(input logic e, input logic [3:0] d);
        if (!e)                  return "R2";
        if (d > 4'd9)            return "R3";
        if (d == 4'd6 || d == 4'd7) return "R7 R1";
        return "R1 R4 R5 R6";
    endfunction

    task automatic check(input string req, input logic [6:0] act, input logic [6:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h (en=%0b digit=%0d)", req, act, exp, en, digit);
        end
    endtask

    // Drive one vector, then check both instances one cycle later.
    task automatic apply(input logic e, input logic [3:0] d);
        @(negedge clk);
        en = e;
        digit = d;
        @(negedge clk);
        check({tag_of(e, d), " R8"}, seg_r, ref_seg(e, d));
        check({tag_of(e, d), " R9"}, seg_c, ref_seg(e, d));
    endtask

    initial begin : watchdog
        repeat (50000) @(posedge clk);
        n_fail++;
        $display("FAIL R8: watchdog expired, actual hung expected done");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

    initial begin : main
        logic [31:0] r;
        r = $urandom(32'h5EC7_0D1A);
        en = 1'b1;
        digit = 4'd8;
        repeat (3) @(negedge clk);
        check("R8 reset", seg_r, 7'h00);
        rst_n = 1'b1;

        // Full sweep of enable and code.
        for (int e = 0; e < 2; e++) begin
            for (int d = 0; d < 16; d++) begin
                apply(e[0], d[3:0]);
            end
        end

        // Directed corners: glyph 6 without top bar, illegal codes enabled.
        apply(1'b1, 4'd6);
        check("R7 digit6 top bar", {6'd0, seg_r[0]}, 7'd0);
        apply(1'b1, 4'd15);
        apply(1'b1, 4'd10);
        apply(1'b0, 4'd8);

        // Reset while a full 8 is shown.
        apply(1'b1, 4'd8);
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check("R8 mid-run reset", seg_r, 7'h00);
        check("R9 comb ignores reset", seg_c, 7'h7F);
        rst_n = 1'b1;

        // Seeded random vectors, biased toward enabled.
        for (int i = 0; i < 300; i++) begin
            r = $urandom;
            apply((r[3:0] != 4'd0), r[7:4]);
        end

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

endmodule